// File: doc/BRIEF.md
# Dual-Preset Reference Selector with Slew-Limited Stepping

This block sits between the configuration registers of a step-down regulator and its reference generator. Two complete operating presets are held in registers. Each preset has an enable gate, a 7-bit output code, a forced-PWM bit and a 2-bit bank. A single select pin picks one preset with no clock latency. The pin is meant for fast switching between two operating points without any bus traffic. The internal converter enable and the mode bit follow the pin combinationally.

The chosen code is held inside a window set by two 4-bit limit nibbles before it becomes the target. An internal reference code then walks toward that target by one code every step period, and a busy flag is raised while it is still on its way. While the converter is off, the reference and the bank are loaded directly. A bank change is therefore never ramped, and a later enable starts from the right code. For checking, the block also reports the output voltage that the current reference and bank stand for, in eighths of a millivolt.

Top module: `vref_preset_ramp`

## Requirements
- R1: With `sel_pin` = 0, preset 0 (`gate0`, `code0`, `fpwm0`, `bank0`) is active. With `sel_pin` = 1, preset 1 is active. `fpwm` equals the active preset's mode bit in the same cycle.
- R2: `core_en` is `en_pin` AND the active preset's gate bit, in the same cycle. A high `en_pin` with gate 0 leaves `core_en` low.
- R3: If the active code is above {`lim_hi`, 3'b111}, the target is {`lim_hi`, 3'b111}.
- R4: If the active code is below {`lim_lo`, 3'b000}, the target is {`lim_lo`, 3'b000}. Otherwise the code passes through unchanged. When the two limits cross, the result is always {`lim_hi`, 3'b111}.
- R5: On every clock edge where `core_en` is low, `ref_code` is loaded with the target.
- R6: While `core_en` is high and `ref_code` differs from the target, `ref_code` moves by exactly one code toward the target once every STEP_CYC edges. The first move comes STEP_CYC edges after the mismatch begins.
- R7: `busy` is high exactly when `ref_code` differs from the target. While `busy` is low and the converter is enabled, `ref_code` holds.
- R8: `bank` takes the active preset's bank on edges where `core_en` is low, and holds its value while `core_en` is high.
- R9: `ref_mv8` = ((97 + `ref_code`) × 25) × 2^`bank`. This is the output voltage in units of 0.125 mV.
- R10: While `rst_n` is low, `ref_code` and `bank` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_pin | input | 1 | External enable pin |
| sel_pin | input | 1 | Preset select pin (0: preset 0, 1: preset 1) |
| gate0 | input | 1 | Preset 0 enable gate |
| code0 | input | 7 | Preset 0 output code |
| fpwm0 | input | 1 | Preset 0 forced-PWM bit |
| bank0 | input | 2 | Preset 0 voltage bank |
| gate1 | input | 1 | Preset 1 enable gate |
| code1 | input | 7 | Preset 1 output code |
| fpwm1 | input | 1 | Preset 1 forced-PWM bit |
| bank1 | input | 2 | Preset 1 voltage bank |
| lim_hi | input | 4 | Upper limit nibble |
| lim_lo | input | 4 | Lower limit nibble |
| core_en | output | 1 | Internal converter enable |
| fpwm | output | 1 | Active forced-PWM bit |
| bank | output | 2 | Applied voltage bank |
| ref_code | output | 7 | Current reference code |
| busy | output | 1 | Reference still moving toward target |
| ref_mv8 | output | 16 | Reference voltage in 0.125 mV units |

## Verification
`core_en` and `fpwm` are pure combinational functions of the pins and presets, so they are checked one nanosecond after the inputs change, with no edge in between. While disabled, `ref_code` and `bank` (and from them `ref_mv8`) update on the first edge after a change, so those checks follow exactly one edge. During a ramp the bench counts edges from the moment the target moves. It expects the code to be start ± floor(n / STEP_CYC), capped at the target, and samples one nanosecond after every edge. The bench uses a short STEP_CYC so that every step boundary, and the cycle just before it, is observed.

// File: rtl/vrp_pkg.sv
`timescale 1ns/1ps
package vrp_pkg;
    localparam int CODE_W       = 7;
    localparam int BANK_W       = 2;
    localparam int NIB_W        = CODE_W - 3;
    localparam int MV_W         = 16;
    localparam int OFFSET_CODES = 97;   // 303.125 mV / 3.125 mV
    localparam int LSB_EIGHTHS  = 25;   // 3.125 mV in 0.125 mV units

    typedef struct packed {
        logic              gate;
        logic [CODE_W-1:0] code;
        logic              fpwm;
        logic [BANK_W-1:0] bank;
    } preset_t;
endpackage

// File: rtl/vrp_preset_mux.sv
`timescale 1ns/1ps
module vrp_preset_mux
    import vrp_pkg::*;
(
    input  logic    sel,
    input  preset_t p0,
    input  preset_t p1,
    output preset_t act
);
    always_comb begin
        act = sel ? p1 : p0;
    end
endmodule

// File: rtl/vrp_code_clamp.sv
`timescale 1ns/1ps
module vrp_code_clamp #(
    parameter int CODE_W = 7,
    parameter int NIB_W  = CODE_W - 3
) (
    input  logic [CODE_W-1:0] code_in,
    input  logic [NIB_W-1:0]  hi_nib,
    input  logic [NIB_W-1:0]  lo_nib,
    output logic [CODE_W-1:0] code_out
);
    localparam int FILL_W = CODE_W - NIB_W;

    logic [CODE_W-1:0] hi_code;
    logic [CODE_W-1:0] lo_code;
    logic [CODE_W-1:0] raised;

    always_comb begin
        hi_code  = {hi_nib, {FILL_W{1'b1}}};
        lo_code  = {lo_nib, {FILL_W{1'b0}}};
        // lower bound first, upper bound last so the upper one wins on a cross
        raised   = (code_in < lo_code) ? lo_code : code_in;
        code_out = (raised > hi_code) ? hi_code : raised;
    end
endmodule

// File: rtl/vrp_ref_slewer.sv
`timescale 1ns/1ps
module vrp_ref_slewer #(
    parameter int CODE_W   = 7,
    parameter int BANK_W   = 2,
    parameter int STEP_CYC = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [CODE_W-1:0] tgt,
    input  logic [BANK_W-1:0] bank_sel,
    output logic [CODE_W-1:0] ref_code,
    output logic [BANK_W-1:0] bank,
    output logic              busy
);
    localparam int CNT_W = $clog2(STEP_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_CYC - 1);

    typedef struct packed {
        logic [CODE_W-1:0] ref_c;
        logic [BANK_W-1:0] bank;
        logic [CNT_W-1:0]  cnt;
    } slew_st_t;

    slew_st_t st_d, st_q;
    logic     busy_w;

    always_comb begin
        st_d   = st_q;
        busy_w = (st_q.ref_c != tgt);
        if (!en) begin
            st_d.ref_c = tgt;
            st_d.bank  = bank_sel;
            st_d.cnt   = '0;
        end else if (!busy_w) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CNT_LAST) begin
            st_d.cnt   = '0;
            st_d.ref_c = (st_q.ref_c < tgt) ? st_q.ref_c + CODE_W'(1)
                                            : st_q.ref_c - CODE_W'(1);
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ref_code = st_q.ref_c;
    assign bank     = st_q.bank;
    assign busy     = busy_w;

    AST_OFF_LOADS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ref_code == $past(tgt)); // R5
    AST_SINGLE_CODE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (ref_code == $past(ref_code) ||
                ref_code == $past(ref_code) + CODE_W'(1) ||
                ref_code == $past(ref_code) - CODE_W'(1))); // R6
    AST_SETTLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !busy) |=> ref_code == $past(ref_code)); // R7
    AST_BANK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> bank == $past(bank)); // R8
endmodule

// File: rtl/vref_preset_ramp.sv
`timescale 1ns/1ps
module vref_preset_ramp
    import vrp_pkg::*;
#(
    parameter int STEP_CYC = 2000   // 10 us at 200 MHz
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_pin,
    input  logic              sel_pin,
    input  logic              gate0,
    input  logic [CODE_W-1:0] code0,
    input  logic              fpwm0,
    input  logic [BANK_W-1:0] bank0,
    input  logic              gate1,
    input  logic [CODE_W-1:0] code1,
    input  logic              fpwm1,
    input  logic [BANK_W-1:0] bank1,
    input  logic [NIB_W-1:0]  lim_hi,
    input  logic [NIB_W-1:0]  lim_lo,
    output logic              core_en,
    output logic              fpwm,
    output logic [BANK_W-1:0] bank,
    output logic [CODE_W-1:0] ref_code,
    output logic              busy,
    output logic [MV_W-1:0]   ref_mv8
);
    preset_t           pre0, pre1, act;
    logic [CODE_W-1:0] tgt;
    logic [31:0]       mv_full;

    assign pre0 = '{gate: gate0, code: code0, fpwm: fpwm0, bank: bank0};
    assign pre1 = '{gate: gate1, code: code1, fpwm: fpwm1, bank: bank1};

    vrp_preset_mux u_mux (
        .sel (sel_pin),
        .p0  (pre0),
        .p1  (pre1),
        .act (act)
    );

    vrp_code_clamp #(.CODE_W(CODE_W), .NIB_W(NIB_W)) u_clamp (
        .code_in  (act.code),
        .hi_nib   (lim_hi),
        .lo_nib   (lim_lo),
        .code_out (tgt)
    );

    assign core_en = en_pin & act.gate;
    assign fpwm    = act.fpwm;

    vrp_ref_slewer #(.CODE_W(CODE_W), .BANK_W(BANK_W), .STEP_CYC(STEP_CYC)) u_slew (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (core_en),
        .tgt      (tgt),
        .bank_sel (act.bank),
        .ref_code (ref_code),
        .bank     (bank),
        .busy     (busy)
    );

    always_comb begin
        mv_full = ((32'(ref_code) + 32'(OFFSET_CODES)) * 32'(LSB_EIGHTHS)) << bank;
    end
    assign ref_mv8 = mv_full[MV_W-1:0];

    AST_GATED_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        core_en |-> en_pin); // R2
    AST_UPPER_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        tgt <= {lim_hi, 3'b111}); // R3
    AST_LOWER_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_hi >= lim_lo) |-> tgt >= {lim_lo, 3'b000}); // R4
endmodule

// File: tb/vref_preset_ramp_bench.sv
`timescale 1ns/1ps
module vref_preset_ramp_bench;
    localparam int STEP = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       en_pin, sel_pin, gate0, gate1, fpwm0, fpwm1;
    logic [6:0] code0, code1;
    logic [1:0] bank0, bank1;
    logic [3:0] lim_hi, lim_lo;
    logic       core_en, fpwm, busy;
    logic [1:0] bank;
    logic [6:0] ref_code;
    logic [15:0] ref_mv8;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    vref_preset_ramp #(.STEP_CYC(STEP)) u_vref_preset_ramp (
        .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .sel_pin(sel_pin),
        .gate0(gate0), .code0(code0), .fpwm0(fpwm0), .bank0(bank0),
        .gate1(gate1), .code1(code1), .fpwm1(fpwm1), .bank1(bank1),
        .lim_hi(lim_hi), .lim_lo(lim_lo),
        .core_en(core_en), .fpwm(fpwm), .bank(bank), .ref_code(ref_code),
        .busy(busy), .ref_mv8(ref_mv8)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic int clamp_exp(input int c, input int hi, input int lo);
        int t;
        t = (c < lo * 8) ? lo * 8 : c;
        if (t > hi * 8 + 7) t = hi * 8 + 7;
        return t;
    endfunction

    initial begin
        int hs[3];
        int ls[3];
        int e;
        hs = '{9, 2, 15};
        ls = '{3, 8, 0};
        rst_n = 0; en_pin = 0; sel_pin = 0; gate0 = 0; gate1 = 0;
        fpwm0 = 0; fpwm1 = 0; code0 = 7'd20; code1 = 7'd30;
        bank0 = 2'd1; bank1 = 2'd2; lim_hi = 4'd15; lim_lo = 4'd0;
        repeat (3) tick();
        chk("R10 ref_code in reset", ref_code, 0);
        chk("R10 bank in reset", bank, 0);
        rst_n = 1;

        // R1 / R2: combinational mux and enable gating
        for (int s = 0; s < 2; s++)
            for (int en = 0; en < 2; en++)
                for (int g = 0; g < 4; g++) begin
                    sel_pin = s[0]; en_pin = en[0];
                    gate0 = g[0]; gate1 = g[1];
                    fpwm0 = g[1]; fpwm1 = g[0];
                    #1;
                    chk("R2 core_en", core_en, en & (s != 0 ? g >> 1 : g & 1));
                    chk("R1 fpwm", fpwm, s != 0 ? g & 1 : g >> 1);
                end

        // R1: code and bank follow the select pin (converter off)
        en_pin = 0; code0 = 7'd10; code1 = 7'd50; bank0 = 2'd1; bank1 = 2'd2;
        sel_pin = 1; tick();
        chk("R1 code preset1", ref_code, 50);
        chk("R1 bank preset1", bank, 2);
        sel_pin = 0; tick();
        chk("R1 code preset0", ref_code, 10);
        chk("R1 bank preset0", bank, 1);

        // R3 / R4 / R5: clamp sweep, loaded directly while off
        for (int k = 0; k < 3; k++) begin
            lim_hi = hs[k][3:0]; lim_lo = ls[k][3:0];
            for (int c = 0; c < 128; c++) begin
                code0 = c[6:0];
                tick();
                e = clamp_exp(c, hs[k], ls[k]);
                if (c > hs[k] * 8 + 7) chk("R3 upper clamp", ref_code, e);
                else                   chk("R4 lower clamp/pass", ref_code, e);
                chk("R5 off load busy", busy, 0);
            end
        end

        // R8 / R9: bank applied while off, millivolt value
        lim_hi = 4'd15; lim_lo = 4'd0;
        for (int b = 0; b < 4; b++)
            for (int k = 0; k < 3; k++) begin
                bank0 = b[1:0]; code0 = 7'(k * 63);
                tick();
                chk("R8 bank while off", bank, b);
                chk("R9 millivolts", ref_mv8, ((97 + k * 63) * 25) << b);
            end

        // R6 / R7 / R8: ramp up while enabled
        bank0 = 2'd1; code0 = 7'd40; gate0 = 1; en_pin = 0;
        tick();
        chk("R5 start code", ref_code, 40);
        en_pin = 1; code0 = 7'd44;
        #1;
        chk("R7 busy on new target", busy, 1);
        for (int n = 1; n <= 20; n++) begin
            tick();
            e = 40 + ((n / STEP) < 4 ? n / STEP : 4);
            chk("R6 ramp up", ref_code, e);
            chk("R7 busy up", busy, (e != 44) ? 1 : 0);
            if (n == 2) bank0 = 2'd3;
            if (n > 2) chk("R8 bank frozen", bank, 1);
        end

        // R6 / R7: ramp down
        code0 = 7'd38;
        for (int n = 1; n <= 28; n++) begin
            tick();
            e = 44 - ((n / STEP) < 6 ? n / STEP : 6);
            chk("R6 ramp down", ref_code, e);
            chk("R7 busy down", busy, (e != 38) ? 1 : 0);
        end
        chk("R9 millivolts enabled", ref_mv8, ((97 + 38) * 25) << 1);

        // R8: bank change applies once disabled
        en_pin = 0;
        tick();
        chk("R8 bank after disable", bank, 3);
        chk("R5 code after disable", ref_code, 38);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule